// File: doc/BRIEF.md
# PoE Powered-Device Classification Sequencer

This block is the digital core of a powered device's front end on a Power over Ethernet port. It follows the port voltage that the power-sourcing equipment applies, step by step: detection, up to five classification probes with a mark return after each one, then power-up. It decides which load the analog circuitry presents at each step, and when the hot-swap gate may turn on. The voltage comparators, the auxiliary-supply sense and the thermal sensor are modelled as single-bit flags. Each flag passes through a synchronizer and a debounce filter before the state machine uses it.

The state machine has six states:
- `ST_IDLE`: detection.
- `ST_CLASS`: classification probe.
- `ST_MARK`: mark return.
- `ST_POWER`: gate on.
- `ST_AUX`: auxiliary-supply override.
- `ST_HOT`: thermal override.

The transitions are:
- idle to class, on a probe.
- class to mark, and mark to class.
- idle, class or mark to power, on turn-on.
- class or mark back to idle, when the port drops under the mark range.
- power to idle, on turn-off.
- any state to idle, on the reset comparator.
- any state to aux, and any state other than aux to hot.
- aux and hot back to idle, once their flag clears.

A counter records how many probes the supply made. It saturates, and it is frozen once power is granted, so the downstream power supply can read the allocation. A static strap marks a high-class device. Such a device changes its classification signature after the second probe.

Top module: `pd_class_seq`

## Requirements
- R1: After reset the outputs are `sig_en`=1, `mark_load_en`=0, `class_en`=0, `class_sel`=0, `gate_en`=0 and `event_cnt`=0.
- R2: Each entry into `ST_CLASS` (from idle or from mark) raises `class_en` and increments `event_cnt` by one.
- R3: In `ST_MARK`, `mark_load_en`=1 and `sig_en`=0. `mark_load_en`, `class_en` and `gate_en` are never high together.
- R4: With `high_class`=1, `class_sel` is 0 during probes 1 and 2 and is 1 during probe 3 and later. With `high_class`=0, `class_sel` stays 0. `class_sel` is high only while `class_en` is high.
- R5: `event_cnt` saturates at 5. A sixth probe leaves it at 5.
- R6: `gate_en` rises only after the conditioned turn-on flag is seen. It then stays high while the port sits between the two thresholds, and it falls when the turn-off flag asserts.
- R7: While `gate_en` is high, and after it falls, `event_cnt` keeps its value. Later probes do not increment it until the next reset clear.
- R8: The reset comparator returns the machine to `ST_IDLE` from any state except aux and hot, and clears the count and the freeze. A drop from class or mark to the signature-only range (signature flag set, mark flag clear) also returns to idle and clears the count.
- R9: While `aux_req` is asserted, `sig_en`, `class_en`, `mark_load_en` and `gate_en` are all 0, whatever the other flags do. The count is cleared.
- R10: While `over_temp` is asserted and aux is not, `gate_en`=0 and `class_en`=0, and `sig_en`=1.
- R11: A flag pulse shorter than `DEB_CYC` cycles, counted after synchronization, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_below_reset | input | 1 | Port below the reset threshold |
| cmp_sig | input | 1 | Port in the signature range |
| cmp_class | input | 1 | Port in the classification range |
| cmp_mark | input | 1 | Port in the mark range |
| cmp_above_on | input | 1 | Port above the turn-on threshold |
| cmp_below_off | input | 1 | Port below the turn-off threshold |
| aux_req | input | 1 | Auxiliary supply present (highest priority) |
| over_temp | input | 1 | Junction overtemperature |
| high_class | input | 1 | Strap: requested class is 5 to 8 |
| sig_en | output | 1 | Connect the detection signature |
| mark_load_en | output | 1 | Connect the low-resistance mark load |
| class_en | output | 1 | Classification signature active |
| class_sel | output | 1 | 0: primary signature, 1: secondary signature |
| gate_en | output | 1 | Hot-swap gate enable |
| event_cnt | output | CNT_W | Probe count, saturating and frozen at power-up |

## Verification
The hardest state to reach from the ports is a frozen count sitting in `ST_IDLE`. The port must first be powered, then pulled through the hysteresis band and below turn-off, but without going under the reset threshold, and then probed again. The bench builds that path from a set of region tasks. Each task drives the comparator flags as one consistent group and holds them for longer than the synchronizer plus debounce latency. The same approach reaches the point past saturation: six probes in a row with mark returns between them.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLASS,
        ST_MARK,
        ST_POWER,
        ST_AUX,
        ST_HOT
    } seq_state_t;

    localparam int F_RST   = 0;
    localparam int F_SIG   = 1;
    localparam int F_CLS   = 2;
    localparam int F_MARK  = 3;
    localparam int F_ON    = 4;
    localparam int F_OFF   = 5;
    localparam int F_AUX   = 6;
    localparam int F_OT    = 7;
    localparam int N_FLAGS = 8;
endpackage

// File: rtl/pd_flag_cond.sv
module pd_flag_cond #(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] clean
);
    localparam int DW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic [SYNC_STAGES-1:0] sync_q;
        logic [DW-1:0]          run_q;
        logic                   out_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], raw[g]};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
                out_q <= 1'b0;
            end else if (sync_q[SYNC_STAGES-1] == out_q) begin
                run_q <= '0;
            end else if (run_q == DW'(DEB_CYC - 1)) begin
                run_q <= '0;
                out_q <= sync_q[SYNC_STAGES-1];
            end else begin
                run_q <= run_q + 1'b1;
            end
        end

        assign clean[g] = out_q;
    end
endmodule

// File: rtl/pd_event_ctr.sv
module pd_event_ctr #(
    parameter int MAX_EVENTS = 5,
    parameter int CNT_W      = $clog2(MAX_EVENTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             freeze_set,
    output logic [CNT_W-1:0] cnt
);
    logic frozen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            frozen_q <= 1'b0;
        end else if (clr) begin
            cnt      <= '0;
            frozen_q <= 1'b0;
        end else begin
            if (freeze_set) begin
                frozen_q <= 1'b1;
            end
            if (inc && !frozen_q && cnt != CNT_W'(MAX_EVENTS)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pd_class_seq.sv
module pd_class_seq
    import pd_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 4,
    parameter int MAX_EVENTS  = 5,
    parameter int ALT_AFTER   = 2,
    parameter int CNT_W       = $clog2(MAX_EVENTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_below_reset,
    input  logic             cmp_sig,
    input  logic             cmp_class,
    input  logic             cmp_mark,
    input  logic             cmp_above_on,
    input  logic             cmp_below_off,
    input  logic             aux_req,
    input  logic             over_temp,
    input  logic             high_class,
    output logic             sig_en,
    output logic             mark_load_en,
    output logic             class_en,
    output logic             class_sel,
    output logic             gate_en,
    output logic [CNT_W-1:0] event_cnt
);
    logic [N_FLAGS-1:0] raw_flags, flags;
    seq_state_t state_q, state_d;
    logic aux_c, ot_c, rst_c, sig_c, cls_c, mark_c, above_on_c, below_off_c;
    logic drop_to_idle, cnt_clr, cnt_inc, cnt_freeze;

    assign raw_flags[F_RST]  = cmp_below_reset;
    assign raw_flags[F_SIG]  = cmp_sig;
    assign raw_flags[F_CLS]  = cmp_class;
    assign raw_flags[F_MARK] = cmp_mark;
    assign raw_flags[F_ON]   = cmp_above_on;
    assign raw_flags[F_OFF]  = cmp_below_off;
    assign raw_flags[F_AUX]  = aux_req;
    assign raw_flags[F_OT]   = over_temp;

    pd_flag_cond #(
        .N(N_FLAGS), .SYNC_STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)
    ) u_cond (
        .clk(clk), .rst_n(rst_n), .raw(raw_flags), .clean(flags)
    );

    assign rst_c       = flags[F_RST];
    assign sig_c       = flags[F_SIG];
    assign cls_c       = flags[F_CLS];
    assign mark_c      = flags[F_MARK];
    assign above_on_c  = flags[F_ON];
    assign below_off_c = flags[F_OFF];
    assign aux_c       = flags[F_AUX];
    assign ot_c        = flags[F_OT];

    // next-state: aux > overtemp > reset comparator > per-state moves
    always_comb begin
        state_d      = state_q;
        drop_to_idle = 1'b0;
        if (aux_c) begin
            state_d = ST_AUX;
        end else if (ot_c) begin
            state_d = ST_HOT;
        end else if (rst_c) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (above_on_c)  state_d = ST_POWER;
                    else if (cls_c)  state_d = ST_CLASS;
                end
                ST_CLASS: begin
                    if (above_on_c)  state_d = ST_POWER;
                    else if (mark_c) state_d = ST_MARK;
                    else if (sig_c) begin
                        state_d      = ST_IDLE;
                        drop_to_idle = 1'b1;
                    end
                end
                ST_MARK: begin
                    if (above_on_c)  state_d = ST_POWER;
                    else if (cls_c)  state_d = ST_CLASS;
                    else if (sig_c && !mark_c) begin
                        state_d      = ST_IDLE;
                        drop_to_idle = 1'b1;
                    end
                end
                ST_POWER: begin
                    if (below_off_c) state_d = ST_IDLE;
                end
                ST_AUX:   state_d = ST_IDLE;
                ST_HOT:   state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign cnt_clr    = aux_c || (rst_c && !ot_c) || drop_to_idle;
    assign cnt_inc    = (state_d == ST_CLASS) && (state_q != ST_CLASS);
    assign cnt_freeze = (state_d == ST_POWER);

    pd_event_ctr #(
        .MAX_EVENTS(MAX_EVENTS), .CNT_W(CNT_W)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .freeze_set(cnt_freeze), .cnt(event_cnt)
    );

    // Moore outputs
    always_comb begin
        sig_en       = 1'b0;
        mark_load_en = 1'b0;
        class_en     = 1'b0;
        gate_en      = 1'b0;
        unique case (state_q)
            ST_IDLE:  sig_en = 1'b1;
            ST_CLASS: begin
                sig_en   = 1'b1;
                class_en = 1'b1;
            end
            ST_MARK:  mark_load_en = 1'b1;
            ST_POWER: gate_en = 1'b1;
            ST_AUX:   sig_en = 1'b0;
            ST_HOT:   sig_en = 1'b1;
            default:  sig_en = 1'b0;
        endcase
        class_sel = class_en && high_class && (event_cnt > CNT_W'(ALT_AFTER));
    end
endmodule

// File: rtl/pd_class_seq_chk.sv
module pd_class_seq_chk #(
    parameter int CNT_W      = 3,
    parameter int MAX_EVENTS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aux_c,
    input logic             ot_c,
    input logic             above_on_c,
    input logic             gate_en,
    input logic             class_en,
    input logic             mark_load_en,
    input logic             class_sel,
    input logic             sig_en,
    input logic [CNT_W-1:0] event_cnt
);
    assert_cnt_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        event_cnt <= CNT_W'(MAX_EVENTS));

    assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mark_load_en, class_en, gate_en}));

    assert_sel_in_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        class_sel |-> class_en);

    assert_gate_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(above_on_c));

    assert_cnt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && $past(gate_en)) |-> $stable(event_cnt));

    assert_aux_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        aux_c |=> (!gate_en && !sig_en && !class_en && !mark_load_en));

    assert_hot_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_c && !aux_c) |=> (!gate_en && !class_en));
endmodule

bind pd_class_seq pd_class_seq_chk #(
    .CNT_W(CNT_W), .MAX_EVENTS(MAX_EVENTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .aux_c(aux_c), .ot_c(ot_c),
    .above_on_c(above_on_c), .gate_en(gate_en), .class_en(class_en),
    .mark_load_en(mark_load_en), .class_sel(class_sel), .sig_en(sig_en),
    .event_cnt(event_cnt)
);

// File: tb/test_pd_class_seq.sv
module test_pd_class_seq;
    localparam int CNT_W  = 3;
    localparam int SETTLE = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_reset = 1'b1, sig = 1'b0, cls = 1'b0, mark = 1'b0;
    logic above_on = 1'b0, below_off = 1'b1, aux = 1'b0, ot = 1'b0, hc = 1'b0;
    logic sig_en, mark_load_en, class_en, class_sel, gate_en;
    logic [CNT_W-1:0] event_cnt;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pd_class_seq i_pd_class_seq (
        .clk(clk), .rst_n(rst_n),
        .cmp_below_reset(below_reset), .cmp_sig(sig), .cmp_class(cls),
        .cmp_mark(mark), .cmp_above_on(above_on), .cmp_below_off(below_off),
        .aux_req(aux), .over_temp(ot), .high_class(hc),
        .sig_en(sig_en), .mark_load_en(mark_load_en), .class_en(class_en),
        .class_sel(class_sel), .gate_en(gate_en), .event_cnt(event_cnt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    // port voltage regions, each driven as one consistent flag set
    task automatic region(input int r);
        @(negedge clk);
        {below_reset, sig, cls, mark, above_on, below_off} = 6'b0;
        case (r)
            0: begin below_reset = 1'b1; below_off = 1'b1; end // near zero
            1: begin sig = 1'b1; below_off = 1'b1; end          // signature only
            2: begin cls = 1'b1; below_off = 1'b1; end          // class probe
            3: begin sig = 1'b1; mark = 1'b1; below_off = 1'b1; end // mark
            4: begin above_on = 1'b1; end                        // powered
            5: begin end                                         // hysteresis band
            default: begin below_off = 1'b1; end                 // below off, above class
        endcase
        settle();
    endtask

    task automatic t_reset_state();
        chk("R1", "sig_en", sig_en, 1);
        chk("R1", "mark_load_en", mark_load_en, 0);
        chk("R1", "class_en", class_en, 0);
        chk("R1", "class_sel", class_sel, 0);
        chk("R1", "gate_en", gate_en, 0);
        chk("R1", "event_cnt", event_cnt, 0);
    endtask

    task automatic t_five_events_high();
        hc = 1'b1;
        region(1);
        for (int e = 1; e <= 6; e++) begin
            region(2);
            chk("R2", "class_en", class_en, 1);
            chk("R5", "event_cnt", event_cnt, (e > 5) ? 5 : e);
            chk("R4", "class_sel high", class_sel, (e > 2) ? 1 : 0);
            region(3);
            chk("R3", "mark_load_en", mark_load_en, 1);
            chk("R3", "sig_en in mark", sig_en, 0);
        end
        region(0);
        chk("R8", "cnt after reset cmp", event_cnt, 0);
    endtask

    task automatic t_low_class();
        hc = 1'b0;
        region(1);
        for (int e = 1; e <= 4; e++) begin
            region(2);
            chk("R4", "class_sel low", class_sel, 0);
            region(3);
        end
        chk("R2", "cnt low", event_cnt, 4);
        region(1);
        chk("R8", "drop to signature clears", event_cnt, 0);
        chk("R8", "idle sig_en", sig_en, 1);
        region(0);
    endtask

    task automatic t_power_hyst();
        region(1);
        region(2); region(3); region(2); region(3);
        region(5);
        chk("R6", "gate off below on", gate_en, 0);
        region(4);
        chk("R6", "gate on", gate_en, 1);
        chk("R7", "cnt at power", event_cnt, 2);
        region(5);
        chk("R6", "gate held in band", gate_en, 1);
        region(6);
        chk("R6", "gate off below off", gate_en, 0);
        region(2);
        chk("R7", "cnt frozen after probe", event_cnt, 2);
        region(0);
        chk("R8", "cnt cleared", event_cnt, 0);
    endtask

    task automatic t_aux();
        region(1);
        region(2);
        aux = 1'b1;
        settle();
        chk("R9", "class_en aux", class_en, 0);
        chk("R9", "sig_en aux", sig_en, 0);
        chk("R9", "cnt aux", event_cnt, 0);
        region(4);
        chk("R9", "gate aux", gate_en, 0);
        aux = 1'b0;
        settle();
        chk("R6", "gate after aux", gate_en, 1);
        region(0);
    endtask

    task automatic t_overtemp();
        region(4);
        chk("R6", "gate before ot", gate_en, 1);
        ot = 1'b1;
        settle();
        chk("R10", "gate ot", gate_en, 0);
        region(2);
        chk("R10", "class_en ot", class_en, 0);
        chk("R10", "sig_en ot", sig_en, 1);
        ot = 1'b0;
        region(0);
    endtask

    task automatic t_glitch();
        region(1);
        @(negedge clk);
        cls = 1'b1; sig = 1'b0;
        repeat (2) @(negedge clk);
        cls = 1'b0; sig = 1'b1;
        settle();
        chk("R11", "glitch class_en", class_en, 0);
        chk("R11", "glitch cnt", event_cnt, 0);
        region(0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset_state();
        t_five_events_high();
        t_low_class();
        t_power_hyst();
        t_aux();
        t_overtemp();
        t_glitch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule